// File: doc/BRIEF.md
# Display Data Channel Slave Front End

This block sits between the two display data channel wires and a small register port. After reset it is in the unidirectional DDC1 mode, with the force bit in the control register set. Software clears that bit to arm the block. The next low pulse on SCL then moves the block into the bidirectional DDC2B slave mode and raises a mode-change flag. Setting the force bit again returns the block to DDC1 mode, which also raises the mode-change flag.

In DDC2B mode the block watches the bus for START, repeated START and STOP conditions. It shifts in the first byte after a START as a 7-bit address followed by a direction bit, and it keeps that byte in the receive register. The address is compared with a fixed address (8-bit form 0xA0, 7-bit value 0x50) and with a programmable 7-bit address. On a match the block pulls SDA low on the ninth clock and then follows the direction bit. When the master writes, the block acknowledges and stores each byte. When the master reads, the block shifts out the transmit register MSB first until the master does not acknowledge. Every event sets a sticky flag. Each flag drives its own interrupt line through an enable mask. SCL and SDA are brought in through two-flop synchronizers, and SDA is driven by an open-drain enable.

Top module: `ddc_slave_top`

## Requirements
- R1: After reset the control register reads 0x01 (bit0 force = 1, bit1 mode = 0, meaning DDC1), the flag register (address 1) reads 0, sda_oe is 0 and irq is 0.
- R2: While the force bit is 0 and the block is in DDC1 mode, a low pulse on SCL switches it to DDC2B (control bit1 = 1) and sets flag bit6. While the force bit is 1, an SCL pulse leaves the block in DDC1 mode.
- R3: Writing 1 to the force bit while in DDC2B mode returns the block to DDC1 mode and sets flag bit6. In DDC1 mode the block never drives SDA and never acknowledges an address.
- R4: A START (SDA falling while SCL is high) in DDC2B mode sets flag bit0. The bit stays set until a 1 is written to bit0 of the flag register. Writing 1 to a bit of the flag register clears that bit.
- R5: The first byte after a START is stored in the receive register (address 4). If bits 7:1 of that byte equal 0x50 or the programmable address (address 3, bits 6:0), the block sets flag bit1 and pulls SDA low for the ninth clock.
- R6: If the address does not match, the block sets no hit flag, drives no ACK, and ignores all following SDA activity until the next START.
- R7: If the address byte has bit0 = 0 (master writes), each following byte is acknowledged on the ninth clock, stored in the receive register, and sets flag bit2.
- R8: If the address byte has bit0 = 1 (master reads), the transmit register (address 5) is sent MSB first, one byte per nine clocks. A master ACK sets flag bit3 and starts the next byte. A master NAK sets flag bit4, and after that the block leaves SDA released.
- R9: A STOP (SDA rising while SCL is high) sets flag bit5 and returns the slave to idle. Bytes clocked after the STOP and before a START are not acknowledged.
- R10: A repeated START, with no STOP before it, sets flag bit0 and restarts address reception, so a new address and direction take effect.
- R11: Each bit i of irq equals flag bit i ANDed with bit i of the enable register (address 2).
- R12: sda_oe changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line as seen at the pin |
| sda_i | input | 1 | SDA line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 control, 1 flags, 2 enable, 3 own address, 4 receive, 5 transmit |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| irq | output | 7 | Interrupt lines, one per flag bit |

## Verification
An edge at the pins reaches the protocol state three clock edges later: two synchronizer flops, then the edge-detect compare feeding the registered state. Flags, receive data and sda_oe therefore settle within four cycles of the SCL or SDA edge that causes them. The bench holds every bus level for eight cycles and reads the line at the end of each SCL high phase, so the slave's ACK and data bits are stable when it samples them. Register reads are combinational and are taken one time step after a falling clock edge. Flag and interrupt checks happen only after a whole bit or condition has finished on the bus.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
    localparam int BYTE_W  = 8;
    localparam int NFLAGS  = 7;
    localparam int REG_AW  = 3;

    localparam int FL_START = 0;
    localparam int FL_HIT   = 1;
    localparam int FL_RX    = 2;
    localparam int FL_TX    = 3;
    localparam int FL_NAK   = 4;
    localparam int FL_STOP  = 5;
    localparam int FL_MODE  = 6;

    localparam logic [REG_AW-1:0] RA_CTRL  = 3'd0;
    localparam logic [REG_AW-1:0] RA_FLAGS = 3'd1;
    localparam logic [REG_AW-1:0] RA_EN    = 3'd2;
    localparam logic [REG_AW-1:0] RA_OWN   = 3'd3;
    localparam logic [REG_AW-1:0] RA_RX    = 3'd4;
    localparam logic [REG_AW-1:0] RA_TX    = 3'd5;

    typedef enum logic [2:0] {
        LK_IDLE, LK_ADDR, LK_AACK, LK_WRITE, LK_WACK, LK_READ, LK_RACK, LK_SKIP
    } link_state_e;

    typedef struct packed {
        link_state_e        state;
        logic               mode;
        logic [3:0]         cnt;
        logic [BYTE_W-1:0]  sh;
        logic               hit;
        logic               rw;
        logic               oe;
        logic               scl_p;
        logic               sda_p;
    } link_regs_t;

    typedef struct packed {
        logic               force_ddc1;
        logic [NFLAGS-1:0]  flags;
        logic [NFLAGS-1:0]  en;
        logic [6:0]         own;
        logic [BYTE_W-1:0]  rx;
        logic [BYTE_W-1:0]  tx;
    } ctl_regs_t;
endpackage

// File: rtl/ddc_sync.sv
module ddc_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] dout
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_q;
        logic [STAGES-1:0] chain_d;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], din[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign dout[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/ddc_link.sv
module ddc_link
    import ddc_pkg::*;
#(
    parameter logic [6:0] FIXED_ADDR = 7'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              force_i,
    input  logic [6:0]        own_addr_i,
    input  logic [BYTE_W-1:0] tx_byte_i,
    output logic              sda_oe_o,
    output logic              mode_o,
    output logic [NFLAGS-1:0] ev_o,
    output logic              rx_load_o,
    output logic [BYTE_W-1:0] rx_byte_o
);
    link_regs_t q, d;

    logic scl_rise, scl_fall, start_det, stop_det;
    logic [BYTE_W-1:0] nbyte;
    logic match;

    always_comb begin
        scl_rise  = scl_s && !q.scl_p;
        scl_fall  = !scl_s && q.scl_p;
        start_det = scl_s && q.scl_p && q.sda_p && !sda_s;
        stop_det  = scl_s && q.scl_p && !q.sda_p && sda_s;
        nbyte     = {q.sh[BYTE_W-2:0], sda_s};
        match     = (nbyte[7:1] == FIXED_ADDR) || (nbyte[7:1] == own_addr_i);
    end

    always_comb begin
        d         = q;
        d.scl_p   = scl_s;
        d.sda_p   = sda_s;
        ev_o      = '0;
        rx_load_o = 1'b0;
        rx_byte_o = nbyte;
        if (!q.mode) begin
            d.oe = 1'b0;
            if (!force_i && scl_rise) begin
                d.mode        = 1'b1;
                d.state       = LK_IDLE;
                ev_o[FL_MODE] = 1'b1;
            end
        end else if (force_i) begin
            d.mode        = 1'b0;
            d.state       = LK_IDLE;
            d.oe          = 1'b0;
            ev_o[FL_MODE] = 1'b1;
        end else if (start_det) begin
            d.state        = LK_ADDR;
            d.cnt          = '0;
            d.hit          = 1'b0;
            d.oe           = 1'b0;
            ev_o[FL_START] = 1'b1;
        end else if (stop_det) begin
            d.state       = LK_IDLE;
            d.cnt         = '0;
            d.oe          = 1'b0;
            ev_o[FL_STOP] = 1'b1;
        end else begin
            case (q.state)
                LK_ADDR: begin
                    if (scl_rise && q.cnt < 4'd8) begin
                        d.sh  = nbyte;
                        d.cnt = q.cnt + 4'd1;
                        if (q.cnt == 4'd7) begin
                            rx_load_o    = 1'b1;
                            d.hit        = match;
                            d.rw         = sda_s;
                            ev_o[FL_HIT] = match;
                        end
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        if (q.hit) begin
                            d.oe    = 1'b1;
                            d.state = LK_AACK;
                        end else begin
                            d.state = LK_SKIP;
                        end
                    end
                end
                LK_AACK, LK_RACK: begin
                    if (q.state == LK_RACK && scl_rise) begin
                        if (sda_s) begin
                            ev_o[FL_NAK] = 1'b1;
                            d.state      = LK_SKIP;
                        end else begin
                            ev_o[FL_TX] = 1'b1;
                            d.cnt       = 4'd1;
                        end
                    end else if (scl_fall && (q.state == LK_AACK || q.cnt == 4'd1)) begin
                        if (q.rw) begin
                            d.oe    = !tx_byte_i[BYTE_W-1];
                            d.sh    = {tx_byte_i[BYTE_W-2:0], 1'b0};
                            d.cnt   = 4'd1;
                            d.state = LK_READ;
                        end else begin
                            d.oe    = 1'b0;
                            d.cnt   = '0;
                            d.state = LK_WRITE;
                        end
                    end
                end
                LK_WRITE: begin
                    if (scl_rise && q.cnt < 4'd8) begin
                        d.sh  = nbyte;
                        d.cnt = q.cnt + 4'd1;
                        if (q.cnt == 4'd7) begin
                            rx_load_o   = 1'b1;
                            ev_o[FL_RX] = 1'b1;
                        end
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        d.oe    = 1'b1;
                        d.state = LK_WACK;
                    end
                end
                LK_WACK: begin
                    if (scl_fall) begin
                        d.oe    = 1'b0;
                        d.cnt   = '0;
                        d.state = LK_WRITE;
                    end
                end
                LK_READ: begin
                    if (scl_fall) begin
                        if (q.cnt == 4'd8) begin
                            d.oe    = 1'b0;
                            d.cnt   = '0;
                            d.state = LK_RACK;
                        end else begin
                            d.oe  = !q.sh[BYTE_W-1];
                            d.sh  = {q.sh[BYTE_W-2:0], 1'b0};
                            d.cnt = q.cnt + 4'd1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= LK_IDLE;
            q.scl_p <= 1'b1;
            q.sda_p <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = q.oe;
    assign mode_o   = q.mode;

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (q.oe != $past(q.oe)) |-> (!$past(scl_s) || $past(force_i))); // R12

    AST_NO_DRIVE_DDC1: assert property (@(posedge clk) disable iff (!rst_n)
        !q.mode |-> !q.oe); // R3

    AST_ACK_ONLY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == LK_AACK && $past(q.state) != LK_AACK) |-> (q.hit && q.oe)); // R5
endmodule

// File: rtl/ddc_regs.sv
module ddc_regs
    import ddc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic [NFLAGS-1:0] ev_i,
    input  logic              rx_load_i,
    input  logic [BYTE_W-1:0] rx_byte_i,
    input  logic              mode_i,
    output logic              force_o,
    output logic [6:0]        own_addr_o,
    output logic [BYTE_W-1:0] tx_byte_o,
    output logic [NFLAGS-1:0] irq_o
);
    ctl_regs_t q, d;

    always_comb begin
        d = q;
        if (reg_we) begin
            case (reg_addr)
                RA_CTRL:  d.force_ddc1 = reg_wdata[0];
                RA_FLAGS: d.flags      = q.flags & ~reg_wdata[NFLAGS-1:0];
                RA_EN:    d.en         = reg_wdata[NFLAGS-1:0];
                RA_OWN:   d.own        = reg_wdata[6:0];
                RA_TX:    d.tx         = reg_wdata;
                default: ;
            endcase
        end
        d.flags = d.flags | ev_i;
        if (rx_load_i) d.rx = rx_byte_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q            <= '0;
            q.force_ddc1 <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (reg_addr)
            RA_CTRL:  reg_rdata = {6'd0, mode_i, q.force_ddc1};
            RA_FLAGS: reg_rdata = {1'b0, q.flags};
            RA_EN:    reg_rdata = {1'b0, q.en};
            RA_OWN:   reg_rdata = {1'b0, q.own};
            RA_RX:    reg_rdata = q.rx;
            RA_TX:    reg_rdata = q.tx;
            default:  reg_rdata = '0;
        endcase
    end

    assign force_o    = q.force_ddc1;
    assign own_addr_o = q.own;
    assign tx_byte_o  = q.tx;
    assign irq_o      = q.flags & q.en;

    AST_START_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.flags[FL_START]) && !($past(reg_we) && $past(reg_addr) == RA_FLAGS
          && $past(reg_wdata[FL_START]))) |-> q.flags[FL_START]); // R4

    AST_MODE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_i) |-> q.flags[FL_MODE]); // R2
endmodule

// File: rtl/ddc_slave_top.sv
module ddc_slave_top
    import ddc_pkg::*;
#(
    parameter logic [6:0] FIXED_ADDR  = 7'h50,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic [NFLAGS-1:0] irq
);
    logic [1:0]        bus_s;
    logic              force_w, mode_w, rx_load_w;
    logic [6:0]        own_w;
    logic [BYTE_W-1:0] tx_w, rx_w;
    logic [NFLAGS-1:0] ev_w;

    ddc_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_i, sda_i}),
        .dout (bus_s)
    );

    ddc_link #(.FIXED_ADDR(FIXED_ADDR)) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (bus_s[1]),
        .sda_s     (bus_s[0]),
        .force_i   (force_w),
        .own_addr_i(own_w),
        .tx_byte_i (tx_w),
        .sda_oe_o  (sda_oe),
        .mode_o    (mode_w),
        .ev_o      (ev_w),
        .rx_load_o (rx_load_w),
        .rx_byte_o (rx_w)
    );

    ddc_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ev_i      (ev_w),
        .rx_load_i (rx_load_w),
        .rx_byte_i (rx_w),
        .mode_i    (mode_w),
        .force_o   (force_w),
        .own_addr_o(own_w),
        .tx_byte_o (tx_w),
        .irq_o     (irq)
    );
endmodule

// File: tb/ddc_slave_top_bench.sv
`timescale 1ns/1ps
module ddc_slave_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic [6:0] irq;
    logic       sda_line;
    int         checks = 0;
    int         errors = 0;
    int         scl_hi = 0;
    int         oe_bad = 0;
    logic       oe_prev = 1'b0;
    bit         done = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    ddc_slave_top u_ddc_slave_top (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // R12 monitor: SCL has been high for several cycles, so its synchronized copy is high too
    always @(posedge clk) begin
        if (sda_oe != oe_prev && scl_hi >= 4) oe_bad++;
        oe_prev <= sda_oe;
        scl_hi  <= scl_m ? scl_hi + 1 : 0;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (8) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic bus_bit(input logic b, output logic r);
        scl_m = 1'b0; half();
        sda_m = b;    half();
        scl_m = 1'b1; half();
        r = sda_line;
    endtask

    task automatic bus_start();
        scl_m = 1'b0; half();
        sda_m = 1'b1; half();
        scl_m = 1'b1; half();
        sda_m = 1'b0; half();
    endtask

    task automatic bus_stop();
        scl_m = 1'b0; half();
        sda_m = 1'b0; half();
        scl_m = 1'b1; half();
        sda_m = 1'b1; half();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bus_bit(v[i], r);
        bus_bit(1'b1, ack);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, r);
            v[i] = r;
        end
        bus_bit(mack, r);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(3'd0, v); check(v == 8'h01, "R1 ctrl", v, 8'h01);
        rd(3'd1, v); check(v == 8'h00, "R1 flags", v, 0);
        check(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
        check(irq == 7'd0, "R1 irq", irq, 0);
    endtask

    task automatic t_mode_switch();
        logic [7:0] v;
        scl_m = 1'b0; half(); scl_m = 1'b1; half();
        rd(3'd0, v); check(v == 8'h01, "R2 no switch while forced", v, 8'h01);
        wr(3'd0, 8'h00);
        scl_m = 1'b0; half(); scl_m = 1'b1; half();
        rd(3'd0, v); check(v == 8'h02, "R2 ctrl after pulse", v, 8'h02);
        rd(3'd1, v); check(v == 8'h40, "R2 mode flag", v, 8'h40);
        wr(3'd1, 8'h7F);
        rd(3'd1, v); check(v == 8'h00, "R4 w1c clears flags", v, 0);
    endtask

    task automatic t_write();
        logic [7:0] v;
        logic a;
        bus_start();
        rd(3'd1, v); check(v == 8'h01, "R4 start flag", v, 8'h01);
        send_byte(8'hA0, a); check(a == 1'b0, "R5 ack fixed addr", a, 0);
        rd(3'd4, v); check(v == 8'hA0, "R5 rx holds address", v, 8'hA0);
        rd(3'd1, v); check(v == 8'h03, "R5 hit flag", v, 8'h03);
        send_byte(8'h5A, a); check(a == 1'b0, "R7 data ack", a, 0);
        rd(3'd4, v); check(v == 8'h5A, "R7 rx data", v, 8'h5A);
        rd(3'd1, v); check(v == 8'h07, "R7 rx flag and R4 start still set", v, 8'h07);
        wr(3'd1, 8'h01);
        rd(3'd1, v); check(v == 8'h06, "R4 start cleared alone", v, 8'h06);
        bus_stop();
        rd(3'd1, v); check(v[5] == 1'b1, "R9 stop flag", v, 8'h26);
        send_byte(8'h77, a); check(a == 1'b1, "R9 no ack after stop", a, 1);
        rd(3'd4, v); check(v == 8'h5A, "R9 rx unchanged after stop", v, 8'h5A);
        wr(3'd1, 8'h7F);
    endtask

    task automatic t_miss();
        logic [7:0] v;
        logic a;
        bus_start();
        send_byte(8'h42, a); check(a == 1'b1, "R6 no ack on miss", a, 1);
        rd(3'd4, v); check(v == 8'h42, "R5 rx holds missed address", v, 8'h42);
        send_byte(8'h00, a); check(a == 1'b1, "R6 data ignored", a, 1);
        rd(3'd1, v); check(v == 8'h01, "R6 no hit or rx flag", v, 8'h01);
        rd(3'd4, v); check(v == 8'h42, "R6 rx unchanged", v, 8'h42);
        bus_stop();
        wr(3'd1, 8'h7F);
    endtask

    task automatic t_own();
        logic [7:0] v;
        logic a;
        wr(3'd3, 8'h37);
        bus_start();
        send_byte(8'h6E, a); check(a == 1'b0, "R5 ack own addr", a, 0);
        rd(3'd1, v); check(v[1] == 1'b1, "R5 hit on own addr", v[1], 1);
        bus_stop();
        wr(3'd1, 8'h7F);
    endtask

    task automatic t_read();
        logic [7:0] v;
        logic a;
        wr(3'd5, 8'h3C);
        bus_start();
        send_byte(8'hA1, a); check(a == 1'b0, "R8 ack read addr", a, 0);
        recv_byte(1'b0, v); check(v == 8'h3C, "R8 first byte", v, 8'h3C);
        rd(3'd1, v); check(v[3] == 1'b1, "R8 tx flag on ack", v[3], 1);
        recv_byte(1'b1, v); check(v == 8'h3C, "R8 second byte", v, 8'h3C);
        rd(3'd1, v); check(v[4] == 1'b1, "R8 nak flag", v[4], 1);
        recv_byte(1'b1, v); check(v == 8'hFF, "R8 released after nak", v, 8'hFF);
        bus_stop();
        wr(3'd1, 8'h7F);
    endtask

    task automatic t_repeat();
        logic [7:0] v;
        logic a;
        bus_start();
        send_byte(8'hA0, a);
        send_byte(8'h11, a);
        wr(3'd1, 8'h7F);
        bus_start();
        rd(3'd1, v); check(v == 8'h01, "R10 repeated start flag", v, 8'h01);
        send_byte(8'hA1, a); check(a == 1'b0, "R10 readdress ack", a, 0);
        recv_byte(1'b1, v); check(v == 8'h3C, "R10 new direction read", v, 8'h3C);
        bus_stop();
        wr(3'd1, 8'h7F);
    endtask

    task automatic t_irq();
        logic a;
        wr(3'd2, 8'h00);
        bus_start();
        send_byte(8'hA0, a);
        check(irq == 7'd0, "R11 masked irq", irq, 0);
        wr(3'd2, 8'h02);
        @(negedge clk);
        check(irq == 7'h02, "R11 hit irq", irq, 8'h02);
        bus_stop();
        check(irq == 7'h02, "R11 stop masked", irq, 8'h02);
        wr(3'd2, 8'h00);
        wr(3'd1, 8'h7F);
    endtask

    task automatic t_force();
        logic [7:0] v;
        logic a;
        wr(3'd0, 8'h01);
        rd(3'd0, v); check(v == 8'h01, "R3 back to DDC1", v, 8'h01);
        rd(3'd1, v); check(v[6] == 1'b1, "R3 mode flag", v[6], 1);
        bus_start();
        send_byte(8'hA0, a); check(a == 1'b1, "R3 no ack in DDC1", a, 1);
        rd(3'd1, v); check(v[1] == 1'b0, "R3 no hit in DDC1", v[1], 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_mode_switch();
        t_write();
        t_miss();
        t_own();
        t_read();
        t_repeat();
        t_irq();
        t_force();
        check(oe_bad == 0, "R12 sda_oe changed with SCL high", oe_bad, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule